// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block sits between the address stage of a 32-lane SIMT core and the memory pipeline. One memory instruction carries a byte address and an enable bit for every lane, and each enabled lane wants one naturally aligned 4-byte word. The block groups the lanes by the aligned memory unit their word falls in. It then sends one transaction per distinct unit, one per cycle, on a valid/ready channel. Each transaction names the unit's base address and the set of lanes it serves.

A granularity select picks the unit size for the instruction. Wide mode uses 128-byte lines and serves cached loads. Narrow mode uses 32-byte segments and serves uncached loads and stores. When the last transaction of an instruction has been handed off, the block gives a one-cycle report: the number of transactions issued, the bytes the lanes asked for, and the bytes the memory side will move. Their ratio is the access efficiency of the instruction. Address stage and memory side must both honour the handshakes. The address stage holds a new instruction until `in_ready` is high.

Top module: `warp_coalescer`

## Requirements
- R1: `in_ready` is high after reset and whenever no instruction is in progress. It goes low in the cycle after an instruction with at least one enabled lane is accepted, and stays low until the cycle after that instruction's final transaction is handed off.
- R2: With `in_mode` = 0, lanes are grouped by address bits [31:7], and `tx_base` is the shared address with bits [6:0] cleared (128-byte lines).
- R3: With `in_mode` = 1, lanes are grouped by address bits [31:5], and `tx_base` is the shared address with bits [4:0] cleared (32-byte segments).
- R4: Transactions leave in the order of the lowest-numbered lane that references each unit. Bit i of `tx_mask` stands for lane i.
- R5: Every enabled lane appears in exactly one transaction mask of its instruction, and no disabled lane appears in any mask. The number of transactions equals the number of distinct units touched.
- R6: When all enabled lanes address the same word, exactly one transaction is issued, and its mask equals `in_active`.
- R7: An instruction with no enabled lanes produces no transaction. Its report appears in the cycle after acceptance with all three counts zero, and `in_ready` stays high.
- R8: `tx_last` is high on the final transaction of an instruction and low on all others.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_base`, `tx_mask` and `tx_last` hold their values, and `tx_valid` stays high.
- R10: `rpt_valid` pulses for one cycle in the cycle after the final handoff. It carries `rpt_txns` = transaction count, `rpt_req_bytes` = 4 × enabled lanes, and `rpt_moved_bytes` = transaction count × unit size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_mode | input | 1 | Granularity select: 0 = 128-byte lines, 1 = 32-byte segments |
| in_active | input | 32 | Lane enable bits, bit i = lane i |
| in_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Memory side takes the transaction |
| tx_base | output | 32 | Aligned base address of the unit |
| tx_mask | output | 32 | Lanes served by this transaction |
| tx_last | output | 1 | Final transaction of the instruction |
| rpt_valid | output | 1 | One-cycle report pulse |
| rpt_txns | output | 6 | Transactions issued by the instruction |
| rpt_req_bytes | output | 8 | Bytes requested by enabled lanes |
| rpt_moved_bytes | output | 13 | Bytes moved by the transactions |

## Verification
Two events can share a cycle here. One is the report of a finished instruction. The other is the acceptance of the next instruction, because `in_ready` rises in the very cycle `rpt_valid` pulses. The bench keeps `in_valid` asserted back to back across an instruction with no enabled lanes, and across multi-transaction instructions. In that cycle it checks that the report carries the counts of the earlier instruction, and that the transactions which follow belong to the newly accepted one, in the expected order.

// File: rtl/coal_pkg.sv
package coal_pkg;

    // Granularity of the memory units that lanes are grouped into.
    typedef enum logic {
        GRAN_LINE = 1'b0,   // wide lines, cached loads
        GRAN_SEG  = 1'b1    // narrow segments, uncached loads and stores
    } gran_e;

endpackage

// File: rtl/coal_first_lane.sv
// Priority pick of the lowest-numbered set bit.
module coal_first_lane #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/coal_popcount.sv
// Count of set bits in a lane vector.
module coal_popcount #(
    parameter int N  = 32,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/coal_line_match.sv
// Per-lane comparison of unit bases against the unit of the leading lane.
module coal_line_match #(
    parameter int N      = 32,
    parameter int ADDR_W = 32,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*ADDR_W-1:0] addr,
    input  logic [N-1:0]        pend,
    input  logic [IW-1:0]       lead_idx,
    input  logic [ADDR_W-1:0]   low_mask,
    output logic [N-1:0]        match,
    output logic [ADDR_W-1:0]   lead_base
);
    logic [ADDR_W-1:0] lane_base [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            assign lane_base[g] = addr[g*ADDR_W +: ADDR_W] & ~low_mask;
            assign match[g]     = pend[g] && (lane_base[g] == lead_base);
        end
    endgenerate

    assign lead_base = lane_base[lead_idx];
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int LINE_LG2 = 7,
    parameter int SEG_LG2  = 5,
    localparam int IW      = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int REQ_W   = CNT_W + 2,
    localparam int MOV_W   = CNT_W + LINE_LG2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_mode,
    input  logic [LANES-1:0]        in_active,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [ADDR_W-1:0]       tx_base,
    output logic [LANES-1:0]        tx_mask,
    output logic                    tx_last,
    output logic                    rpt_valid,
    output logic [CNT_W-1:0]        rpt_txns,
    output logic [REQ_W-1:0]        rpt_req_bytes,
    output logic [MOV_W-1:0]        rpt_moved_bytes
);
    localparam logic [ADDR_W-1:0] LINE_LOW = ADDR_W'((64'd1 << LINE_LG2) - 64'd1);
    localparam logic [ADDR_W-1:0] SEG_LOW  = ADDR_W'((64'd1 << SEG_LG2) - 64'd1);

    typedef struct packed {
        logic                    busy;
        gran_e                   mode;
        logic [LANES*ADDR_W-1:0] addr;
        logic [LANES-1:0]        pend;
        logic [CNT_W-1:0]        cnt;
        logic [REQ_W-1:0]        reqb;
        logic                    rv;
        logic [CNT_W-1:0]        rtx;
        logic [REQ_W-1:0]        rreq;
        logic [MOV_W-1:0]        rmov;
    } state_t;

    state_t s_d, s_q;

    logic [IW-1:0]     lead_idx;
    logic              lead_any;
    logic [LANES-1:0]  match;
    logic [ADDR_W-1:0] lead_base;
    logic [ADDR_W-1:0] low_mask;
    logic [CNT_W-1:0]  act_cnt;
    logic [CNT_W-1:0]  cnt_inc;
    logic [LANES-1:0]  pend_after;
    logic              final_tx;

    assign low_mask = (s_q.mode == GRAN_SEG) ? SEG_LOW : LINE_LOW;

    coal_first_lane #(.N(LANES)) u_first (
        .req (s_q.pend),
        .idx (lead_idx),
        .any (lead_any)
    );

    coal_line_match #(.N(LANES), .ADDR_W(ADDR_W)) u_match (
        .addr      (s_q.addr),
        .pend      (s_q.pend),
        .lead_idx  (lead_idx),
        .low_mask  (low_mask),
        .match     (match),
        .lead_base (lead_base)
    );

    coal_popcount #(.N(LANES)) u_pop (
        .bits  (in_active),
        .count (act_cnt)
    );

    assign cnt_inc    = s_q.cnt + CNT_W'(1);
    assign pend_after = s_q.pend & ~match;
    assign final_tx   = (pend_after == '0);

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (!s_q.busy) begin
            if (in_valid) begin
                s_d.mode = gran_e'(in_mode);
                s_d.addr = in_addr;
                s_d.pend = in_active;
                s_d.cnt  = '0;
                s_d.reqb = {act_cnt, 2'b00};
                if (in_active == '0) begin
                    s_d.rv   = 1'b1;
                    s_d.rtx  = '0;
                    s_d.rreq = '0;
                    s_d.rmov = '0;
                end else begin
                    s_d.busy = 1'b1;
                end
            end
        end else if (tx_ready && lead_any) begin
            s_d.pend = pend_after;
            s_d.cnt  = cnt_inc;
            if (final_tx) begin
                s_d.busy = 1'b0;
                s_d.rv   = 1'b1;
                s_d.rtx  = cnt_inc;
                s_d.rreq = s_q.reqb;
                s_d.rmov = (s_q.mode == GRAN_SEG) ? (MOV_W'(cnt_inc) << SEG_LG2)
                                                  : (MOV_W'(cnt_inc) << LINE_LG2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready        = !s_q.busy;
    assign tx_valid        = s_q.busy && lead_any;
    assign tx_base         = lead_base;
    assign tx_mask         = match;
    assign tx_last         = final_tx;
    assign rpt_valid       = s_q.rv;
    assign rpt_txns        = s_q.rtx;
    assign rpt_req_bytes   = s_q.rreq;
    assign rpt_moved_bytes = s_q.rmov;
endmodule

module coal_chk #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int LINE_LG2 = 7,
    parameter int SEG_LG2  = 5,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int MOV_W   = CNT_W + LINE_LG2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_mode,
    input logic [LANES-1:0]  in_active,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] tx_base,
    input logic [LANES-1:0]  tx_mask,
    input logic              tx_last,
    input logic              rpt_valid,
    input logic [CNT_W-1:0]  rpt_txns,
    input logic [MOV_W-1:0]  rpt_moved_bytes
);
    logic             mode_c;
    logic [LANES-1:0] served_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_c   <= 1'b0;
            served_c <= '0;
        end else if (in_valid && in_ready) begin
            mode_c   <= in_mode;
            served_c <= '0;
        end else if (tx_valid && tx_ready) begin
            served_c <= served_c | tx_mask;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !in_ready); // R1

    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !mode_c) |-> (tx_base[LINE_LG2-1:0] == '0)); // R2

    AST_SEG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_base[SEG_LG2-1:0] == '0)); // R3

    AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_mask != '0) && ((tx_mask & served_c) == '0))); // R5

    AST_EMPTY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_active == '0)) |=> (rpt_valid && (rpt_txns == '0) && !tx_valid)); // R7

    AST_LAST_THEN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (rpt_valid && in_ready)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_mask) && $stable(tx_last))); // R9

    AST_MOVED_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_moved_bytes == (mode_c ? (MOV_W'(rpt_txns) << SEG_LG2)
                                                  : (MOV_W'(rpt_txns) << LINE_LG2)))); // R10
endmodule

bind warp_coalescer coal_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_LG2(LINE_LG2), .SEG_LG2(SEG_LG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_active(in_active), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_base(tx_base), .tx_mask(tx_mask), .tx_last(tx_last),
    .rpt_valid(rpt_valid), .rpt_txns(rpt_txns), .rpt_moved_bytes(rpt_moved_bytes)
);

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb;
    localparam int L = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic            in_mode = 1'b0;
    logic [L-1:0]    in_active = '0;
    logic [L*32-1:0] in_addr = '0;
    logic            tx_valid;
    logic            tx_ready = 1'b1;
    logic [31:0]     tx_base;
    logic [L-1:0]    tx_mask;
    logic            tx_last;
    logic            rpt_valid;
    logic [5:0]      rpt_txns;
    logic [7:0]      rpt_req_bytes;
    logic [12:0]     rpt_moved_bytes;

    warp_coalescer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_active(in_active), .in_addr(in_addr),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base),
        .tx_mask(tx_mask), .tx_last(tx_last), .rpt_valid(rpt_valid),
        .rpt_txns(rpt_txns), .rpt_req_bytes(rpt_req_bytes),
        .rpt_moved_bytes(rpt_moved_bytes)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed { logic [31:0] base; logic [31:0] mask; logic last; } tx_t;
    typedef struct packed { logic [5:0] n; logic [7:0] req; logic [12:0] mov; } rp_t;

    tx_t exp_tx [$];
    rp_t exp_rp [$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit stall_en = 1'b0;
    logic [31:0] drv_addr [L];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected transactions and report, derived from the grouping rules.
    task automatic predict(input logic mode, input logic [31:0] act);
        logic [31:0] pend;
        logic [31:0] lm;
        int n;
        pend = act;
        lm = mode ? 32'h1F : 32'h7F;
        n = 0;
        while (pend != 0) begin
            int lead;
            tx_t t;
            lead = 0;
            for (int i = L - 1; i >= 0; i--) if (pend[i]) lead = i;
            t.base = drv_addr[lead] & ~lm;
            t.mask = '0;
            for (int i = 0; i < L; i++)
                if (pend[i] && ((drv_addr[i] & ~lm) == t.base)) t.mask[i] = 1'b1;
            pend = pend & ~t.mask;
            t.last = (pend == 0);
            exp_tx.push_back(t);
            n++;
        end
        exp_rp.push_back('{n: 6'(n), req: 8'(4 * $countones(act)),
                           mov: 13'(n * (mode ? 32 : 128))});
    endtask

    // Driver: offers one instruction and returns just after the accepting edge.
    task automatic send(input logic mode, input logic [31:0] act);
        bit got;
        @(negedge clk);
        in_valid  = 1'b1;
        in_mode   = mode;
        in_active = act;
        for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = drv_addr[i];
        predict(mode, act);
        got = 1'b0;
        while (!got) begin
            #5;
            got = in_ready;
            if (!got) @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_tx.size() != 0 || exp_rp.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Ready pattern for the memory side.
    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        forever begin
            @(negedge clk);
            if (stall_en) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                tx_ready = lfsr[0];
            end else begin
                tx_ready = 1'b1;
            end
        end
    end

    // Monitor: compares handoffs and reports against the scoreboard.
    initial begin
        bit          hold_v;
        logic [31:0] hold_base;
        logic [31:0] hold_mask;
        hold_v = 1'b0;
        hold_base = '0;
        hold_mask = '0;
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) begin
                if (hold_v) begin
                    chk(tx_valid && tx_base == hold_base && tx_mask == hold_mask,
                        "R9", "held transaction", tx_base, hold_base);
                end
                hold_v    = tx_valid && !tx_ready;
                hold_base = tx_base;
                hold_mask = tx_mask;
                if (tx_valid && tx_ready) begin
                    if (exp_tx.size() == 0) begin
                        chk(1'b0, "R5", "unexpected transaction", tx_mask, 32'h0);
                    end else begin
                        tx_t e;
                        e = exp_tx.pop_front();
                        chk(tx_base == e.base, "R2 R3", "tx_base", tx_base, e.base);
                        chk(tx_mask == e.mask, "R4 R5", "tx_mask", tx_mask, e.mask);
                        chk(tx_last == e.last, "R8", "tx_last", 32'(tx_last), 32'(e.last));
                    end
                end
                if (rpt_valid) begin
                    if (exp_rp.size() == 0) begin
                        chk(1'b0, "R10", "unexpected report", 32'(rpt_txns), 32'h0);
                    end else begin
                        rp_t r;
                        r = exp_rp.pop_front();
                        chk(rpt_txns == r.n, "R10", "rpt_txns", 32'(rpt_txns), 32'(r.n));
                        chk(rpt_req_bytes == r.req, "R10", "rpt_req_bytes",
                            32'(rpt_req_bytes), 32'(r.req));
                        chk(rpt_moved_bytes == r.mov, "R10", "rpt_moved_bytes",
                            32'(rpt_moved_bytes), 32'(r.mov));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < L; i++) drv_addr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 32'h1);
        chk(tx_valid == 1'b0, "R1", "no tx after reset", 32'(tx_valid), 32'h0);
        chk(rpt_valid == 1'b0, "R10", "no report after reset", 32'(rpt_valid), 32'h0);

        // R2: aligned consecutive words, wide lines -> one transaction
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h1000 + 32'(4 * i);
        send(1'b0, 32'hFFFF_FFFF);
        idle();
        #5;
        chk(in_ready == 1'b0, "R1", "ready low while busy", 32'(in_ready), 32'h0);
        drain();

        // R3 R4: aligned permuted words, narrow segments -> four transactions
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h2000 + 32'(4 * ((i * 7) % L));
        send(1'b1, 32'hFFFF_FFFF);
        idle();
        drain();

        // R2: misaligned consecutive words, wide lines -> two transactions
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h3040 + 32'(4 * i);
        send(1'b0, 32'hFFFF_FFFF);
        idle();
        drain();

        // R3: misaligned consecutive words, narrow segments -> five transactions
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h4010 + 32'(4 * i);
        send(1'b1, 32'hFFFF_FFFF);
        idle();
        drain();

        // R6: broadcast of one word to a subset of lanes
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h5A5C;
        send(1'b0, 32'hF0F0_0F0F);
        idle();
        drain();

        // R9 R5: scattered lines with a stalling memory side, partial enables
        stall_en = 1'b1;
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h8000 + 32'(i * 32'h100) + 32'(4 * (i % 3));
        send(1'b1, 32'hAAAA_5555);
        idle();
        drain();

        // R4: interleaved references revisit earlier units
        for (int i = 0; i < L; i++) drv_addr[i] = 32'h9000 + 32'(32'h80 * ((L - 1 - i) % 3));
        send(1'b0, 32'hFFFF_FFFE);
        idle();
        drain();
        stall_en = 1'b0;

        // R7: empty instruction, with the next one held back to back so that
        // its acceptance coincides with the empty report
        send(1'b0, 32'h0);
        #5;
        chk(rpt_valid == 1'b1, "R7", "empty report timing", 32'(rpt_valid), 32'h1);
        chk(in_ready == 1'b1, "R7", "ready stays high", 32'(in_ready), 32'h1);
        for (int i = 0; i < L; i++) drv_addr[i] = 32'hA000 + 32'(4 * i);
        send(1'b1, 32'h0000_FF01);
        for (int i = 0; i < L; i++) drv_addr[i] = 32'hB100 + 32'(32'h40 * (i % 4));
        send(1'b0, 32'h1234_8765);
        idle();
        drain();

        chk(exp_tx.size() == 0, "R5", "pending transactions",
            32'(exp_tx.size()), 32'h0);
        chk(exp_rp.size() == 0, "R10", "pending reports",
            32'(exp_rp.size()), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule